// File: doc/BRIEF.md
# Four-Way True-LRU Unified Cache Controller

This block is a second-level cache that sits beneath split first-level instruction and data caches and serves both kinds of traffic. Requests arrive one at a time on an upstream valid/ready port carrying a byte address, a write flag, a 32-bit write word and per-byte strobes. Read hits and write hits finish one cycle after acceptance. A miss allocates a line in the set, for reads and for writes alike, and fetches it from main memory over a line-wide downstream port. Any dirty line that is displaced is first written back to memory.

Each set has four ways. Lines are 16 bytes and there are 64 sets. Replacement is exact least-recently-used. Each set keeps a 4x4 bit order matrix. When way w is touched, row w is set to all ones and then column w is cleared. The way whose row is all zeros is the oldest. Tags, data, valid flags, dirty flags and the matrices are held in plain register arrays.

Top module: `cache_lru4_top`

## Requirements
- R1: After reset, reqReady is high, respValid and memValid are low, and no line is valid, so the first access to any address misses.
- R2: A read that hits raises respValid in the first cycle after the request is accepted. respRdata then holds the current 32-bit word at the address, and there is no memory traffic.
- R3: A write that hits replaces only the bytes whose strobe bit is set. Strobe bit i selects byte i of the word (bits 8i+7:8i). Within the line, word k sits at line bits 32k+31:32k, where k is address bits 3:2.
- R4: On a miss whose victim is clean or invalid, exactly one line read is issued at the line-aligned address (low four bits zero), with no writeback. The response follows the refill and carries the fetched word.
- R5: A write miss allocates the line. The controller fetches the line, merges the write into it and marks it dirty, and later reads return the merged data.
- R6: If the victim is dirty, its full 128-bit line is written back to the address built from its own tag and index before the refill read is issued.
- R7: The victim is the lowest-numbered invalid way if one exists, and otherwise the least recently used way. Both read hits and write hits count as uses.
- R8: reqReady stays low from the cycle after acceptance until the response has been given, including the whole writeback and refill.
- R9: The address splits into tag (bits 31:10), set index (bits 9:4) and byte offset (bits 3:0). Addresses in one line share a hit, and activity in one set does not disturb another set.
- R10: While memValid is high and memReady is low, memValid, memWrite and memAddr stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write word |
| reqStrb | input | 4 | Byte strobes for the write word |
| respValid | output | 1 | Response pulse, one per request |
| respRdata | output | 32 | Word read at the request address |
| memValid | output | 1 | Downstream request present |
| memReady | input | 1 | Memory accepts the downstream request |
| memWrite | output | 1 | 1 = line writeback, 0 = line read |
| memAddr | output | 32 | Line-aligned memory address |
| memWdata | output | 128 | Line written back |
| memRespValid | input | 1 | Refill data present |
| memRdata | input | 128 | Refill line |

## Verification
A corrupted order matrix does not show up at once. It appears at the next miss in a full set, as an eviction of the wrong line. That shows as a writeback of an unexpected address, or as an extra refill when a line that should still be resident is later read. A wrong dirty flag appears at that same eviction, as a missing or spurious writeback. A bad data merge or a tag mix-up appears on the very next read of the affected word, as a wrong respRdata. The bench therefore fills one set completely, reorders it through read and write hits, and forces two evictions. After each eviction it probes which lines still hit in one cycle.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } cacheState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the accepted request
    logic commit;   // hit: write merge, dirty set, order touch
    logic fill;     // install refill line in the victim way
    logic wbSel;    // present the victim address on the memory port
  } ctrl_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 64,
  parameter int WAYS       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_t                 ctrl,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqWdata,
  input  logic [WORD_W/8-1:0]   reqStrb,
  input  logic [LINE_BYTES*8-1:0] memRdata,
  output logic                  hit,
  output logic                  victimDirty,
  output logic [WORD_W-1:0]     respRdata,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_BYTES*8-1:0] memWdata
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int STRB_W = WORD_W / 8;
  localparam int WORDS  = LINE_BYTES / STRB_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int WAY_W  = $clog2(WAYS);

  // Latched request
  logic              curWrite;
  logic [ADDR_W-1:0] curAddr;
  logic [WORD_W-1:0] curWdata;
  logic [STRB_W-1:0] curStrb;

  // Storage
  logic [TAG_W-1:0]  tagMem  [SETS][WAYS];
  logic [LINE_W-1:0] dataMem [SETS][WAYS];
  logic [WAYS-1:0]   validMem [SETS];
  logic [WAYS-1:0]   dirtyMem [SETS];
  logic [WAYS-1:0][WAYS-1:0] lruMem [SETS];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;

  assign idx  = curAddr[OFF_W +: IDX_W];
  assign tag  = curAddr[ADDR_W-1 -: TAG_W];
  assign wsel = curAddr[OFF_W-1 -: WSEL_W];

  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] zeroRow;
  logic [WAYS-1:0] invalidVec;
  logic [WAY_W-1:0] hitWay, lruWay, invWay, victimWay;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w]     = validMem[idx][w] && (tagMem[idx][w] == tag);
    assign zeroRow[w]    = (lruMem[idx][w] == '0);
    assign invalidVec[w] = !validMem[idx][w];
  end

  always_comb begin
    hitWay = '0;
    lruWay = '0;
    invWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])     hitWay = WAY_W'(w);
      if (zeroRow[w])    lruWay = WAY_W'(w);
      if (invalidVec[w]) invWay = WAY_W'(w);
    end
  end

  assign victimWay   = (|invalidVec) ? invWay : lruWay;
  assign hit         = |hitVec;
  assign victimDirty = validMem[idx][victimWay] && dirtyMem[idx][victimWay];

  logic [LINE_W-1:0] hitLine, mergedLine;
  assign hitLine   = dataMem[idx][hitWay];
  assign respRdata = hitLine[int'(wsel)*WORD_W +: WORD_W];

  always_comb begin
    mergedLine = hitLine;
    for (int b = 0; b < STRB_W; b++) begin
      if (curStrb[b]) mergedLine[int'(wsel)*WORD_W + b*8 +: 8] = curWdata[b*8 +: 8];
    end
  end

  assign memAddr  = ctrl.wbSel ? {tagMem[idx][victimWay], idx, {OFF_W{1'b0}}}
                               : {tag, idx, {OFF_W{1'b0}}};
  assign memWdata = dataMem[idx][victimWay];

  // Request latch, flags and order matrices
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curAddr  <= '0;
      curWdata <= '0;
      curStrb  <= '0;
      for (int s = 0; s < SETS; s++) begin
        validMem[s] <= '0;
        dirtyMem[s] <= '0;
        lruMem[s]   <= '0;
      end
    end else begin
      if (ctrl.capture) begin
        curWrite <= reqWrite;
        curAddr  <= reqAddr;
        curWdata <= reqWdata;
        curStrb  <= reqStrb;
      end
      if (ctrl.commit) begin
        for (int r = 0; r < WAYS; r++) begin
          if (r == int'(hitWay))
            lruMem[idx][r] <= ~(WAYS'(1) << hitWay);
          else
            lruMem[idx][r] <= lruMem[idx][r] & ~(WAYS'(1) << hitWay);
        end
        if (curWrite) dirtyMem[idx][hitWay] <= 1'b1;
      end
      if (ctrl.fill) begin
        validMem[idx][victimWay] <= 1'b1;
        dirtyMem[idx][victimWay] <= 1'b0;
      end
    end
  end

  // Tag and line storage, no reset
  always_ff @(posedge clk) begin
    if (ctrl.commit && curWrite) dataMem[idx][hitWay] <= mergedLine;
    if (ctrl.fill) begin
      dataMem[idx][victimWay] <= memRdata;
      tagMem[idx][victimWay]  <= tag;
    end
  end

  // A tag appears at most once per set
  assert_one_hit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // The order matrix of the set always names some oldest way
  assert_lru_exists_R7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(zeroRow) != 0);

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  output logic  reqReady,
  output logic  respValid,
  input  logic  hit,
  input  logic  victimDirty,
  output logic  memValid,
  output logic  memWrite,
  input  logic  memReady,
  input  logic  memRespValid,
  output ctrl_t ctrl
);

  cacheState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:      if (reqValid) stateNext = ST_LOOKUP;
      ST_LOOKUP:    if (hit) stateNext = ST_IDLE;
                    else if (victimDirty) stateNext = ST_WRITEBACK;
                    else stateNext = ST_FILL_REQ;
      ST_WRITEBACK: if (memReady) stateNext = ST_FILL_REQ;
      ST_FILL_REQ:  if (memReady) stateNext = ST_FILL_WAIT;
      ST_FILL_WAIT: if (memRespValid) stateNext = ST_LOOKUP;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign respValid = (state == ST_LOOKUP) && hit;
  assign memValid  = (state == ST_WRITEBACK) || (state == ST_FILL_REQ);
  assign memWrite  = (state == ST_WRITEBACK);

  always_comb begin
    ctrl.capture = reqValid && reqReady;
    ctrl.commit  = (state == ST_LOOKUP) && hit;
    ctrl.fill    = (state == ST_FILL_WAIT) && memRespValid;
    ctrl.wbSel   = (state == ST_WRITEBACK);
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memWrite)));

  assert_wb_only_dirty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> victimDirty);

endmodule

// File: rtl/cache_lru4_top.sv
module cache_lru4_top
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 64,
  parameter int WAYS       = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [WORD_W-1:0]       reqWdata,
  input  logic [WORD_W/8-1:0]     reqStrb,
  output logic                    respValid,
  output logic [WORD_W-1:0]       respRdata,
  output logic                    memValid,
  input  logic                    memReady,
  output logic                    memWrite,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [LINE_BYTES*8-1:0] memWdata,
  input  logic                    memRespValid,
  input  logic [LINE_BYTES*8-1:0] memRdata
);

  ctrl_t ctrl;
  logic  hit, victimDirty;

  cache_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .respValid(respValid),
    .hit(hit), .victimDirty(victimDirty),
    .memValid(memValid), .memWrite(memWrite), .memReady(memReady),
    .memRespValid(memRespValid), .ctrl(ctrl)
  );

  cache_datapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_BYTES(LINE_BYTES),
    .SETS(SETS), .WAYS(WAYS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqStrb(reqStrb),
    .memRdata(memRdata), .hit(hit), .victimDirty(victimDirty),
    .respRdata(respRdata), .memAddr(memAddr), .memWdata(memWdata)
  );

  // Downstream address is held during a stalled handshake
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> $stable(memAddr));

endmodule

// File: tb/cache_lru4_top_tb_top.sv
module cache_lru4_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid, reqWrite;
  logic         reqReady;
  logic [31:0]  reqAddr, reqWdata;
  logic [3:0]   reqStrb;
  logic         respValid;
  logic [31:0]  respRdata;
  logic         memValid, memWrite;
  logic         memReady;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic         memRespValid;
  logic [127:0] memRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_lru4_top dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqStrb(reqStrb),
    .respValid(respValid), .respRdata(respRdata),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata),
    .memRespValid(memRespValid), .memRdata(memRdata)
  );

  int checks = 0;
  int fails  = 0;

  // Backing memory and architectural shadow, keyed by address bits 13:4
  logic [127:0] backing [1024];
  logic [31:0]  shadow  [1024][4];

  // Memory model bookkeeping
  int          memReads = 0, memWrites = 0, evtSeq = 0;
  int          lastRdSeq = 0, lastWbSeq = 0;
  logic [31:0] lastRdAddr = '0, lastWbAddr = '0;
  logic [127:0] lastWbData = '0;
  int          waitCnt = 0, respCnt = 0, holdViol = 0, stallSeen = 0;
  logic [31:0] refAddr = '0;
  logic        refWrite = 1'b0;
  logic [127:0] refData = '0;
  int          readyViol = 0;

  function automatic logic [127:0] shadowLine(input logic [31:0] a);
    int k = int'(a[13:4]);
    return {shadow[k][3], shadow[k][2], shadow[k][1], shadow[k][0]};
  endfunction

  always @(negedge clk) begin
    memRespValid = 1'b0;
    if (respCnt > 0) begin
      respCnt--;
      if (respCnt == 0) begin
        memRespValid = 1'b1;
        memRdata = backing[int'(lastRdAddr[13:4])];
      end
    end
    if (memReady) begin
      evtSeq++;
      if (refWrite) begin
        backing[int'(refAddr[13:4])] = refData;
        memWrites++; lastWbAddr = refAddr; lastWbData = refData; lastWbSeq = evtSeq;
      end else begin
        memReads++; lastRdAddr = refAddr; lastRdSeq = evtSeq; respCnt = 2;
      end
      memReady = 1'b0;
      waitCnt = 0;
    end else if (rstN && memValid) begin
      if (waitCnt == 0) begin
        refAddr = memAddr; refWrite = memWrite; refData = memWdata;
        waitCnt = 1;
      end else begin
        stallSeen++;
        if (memAddr !== refAddr || memWrite !== refWrite) holdViol++;
        if (waitCnt == 2) memReady = 1'b1;
        else waitCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqStrb = s;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!respValid && lat < 300) begin
      if (reqReady) readyViol++;
      @(negedge clk);
      lat++;
    end
    if (reqReady) readyViol++;
    rd = respRdata;
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (s[b]) shadow[int'(a[13:4])][int'(a[3:2])][b*8 +: 8] = d[b*8 +: 8];
    end
  endtask

  // Read and verify against the shadow; returns latency
  task automatic readCheck(input logic [31:0] a, input string req, output int lat);
    logic [31:0] rd;
    access(1'b0, a, '0, '0, rd, lat);
    check(rd === shadow[int'(a[13:4])][int'(a[3:2])], req, "read data", rd,
          shadow[int'(a[13:4])][int'(a[3:2])]);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady === 1'b1, "R1", "reqReady after reset", reqReady, 1);
    check(respValid === 1'b0, "R1", "respValid after reset", respValid, 0);
    check(memValid === 1'b0, "R1", "memValid after reset", memValid, 0);
  endtask

  task automatic testReadMissHit();
    int lat, r0, w0;
    r0 = memReads; w0 = memWrites;
    readCheck(32'h0000_0238, "R4", lat);
    check(memReads == r0 + 1, "R4", "refills on cold read", memReads, r0 + 1);
    check(memWrites == w0, "R4", "no writeback on clean miss", memWrites, w0);
    check(lastRdAddr === 32'h0000_0230, "R4", "line-aligned refill address", lastRdAddr, 32'h230);
    check(lat > 1, "R1", "first access misses", lat, 2);
    r0 = memReads;
    readCheck(32'h0000_0238, "R2", lat);
    check(lat == 1, "R2", "read hit latency", lat, 1);
    check(memReads == r0, "R2", "no traffic on hit", memReads, r0);
    readCheck(32'h0000_023C, "R9", lat);
    check(lat == 1, "R9", "same line other offset hits", lat, 1);
  endtask

  task automatic testWriteHit();
    int lat;
    logic [31:0] rd;
    access(1'b1, 32'h0000_0234, 32'hDEAD_BEEF, 4'b0101, rd, lat);
    check(lat == 1, "R3", "write hit latency", lat, 1);
    readCheck(32'h0000_0234, "R3", lat);
    readCheck(32'h0000_0230, "R3", lat);
  endtask

  task automatic testWriteMiss();
    int lat, r0, w0;
    logic [31:0] rd;
    r0 = memReads; w0 = memWrites;
    access(1'b1, 32'h0000_0648, 32'h1122_3344, 4'b1111, rd, lat);
    check(memReads == r0 + 1, "R5", "write miss allocates", memReads, r0 + 1);
    check(memWrites == w0, "R5", "no writeback", memWrites, w0);
    readCheck(32'h0000_0648, "R5", lat);
    check(lat == 1, "R5", "allocated line hits", lat, 1);
  endtask

  function automatic logic [31:0] setAddr(input int k);
    return (32'(k) << 10) | 32'h0000_0054;
  endfunction

  task automatic testLruOrder();
    int lat, r0, w0;
    logic [31:0] rd;
    // Fill ways with T1..T4, T3 made dirty
    readCheck(setAddr(1), "R7", lat);
    readCheck(setAddr(2), "R7", lat);
    access(1'b1, setAddr(3), 32'hCAFE_F00D, 4'b1111, rd, lat);
    readCheck(setAddr(4), "R7", lat);
    // Write hit on T1 makes T2 the oldest
    access(1'b1, setAddr(1), 32'h0BAD_0001, 4'b0011, rd, lat);
    check(lat == 1, "R7", "write hit on T1", lat, 1);
    r0 = memReads; w0 = memWrites;
    readCheck(setAddr(5), "R7", lat);
    check(memWrites == w0, "R7", "clean LRU victim not written back", memWrites, w0);
    check(memReads == r0 + 1, "R7", "one refill", memReads, r0 + 1);
    // Now T3 (dirty) is the oldest
    r0 = memReads; w0 = memWrites;
    readCheck(setAddr(6), "R6", lat);
    check(memWrites == w0 + 1, "R6", "dirty victim written back", memWrites, w0 + 1);
    check(lastWbAddr === (setAddr(3) & ~32'hF), "R6", "writeback address", lastWbAddr,
          setAddr(3) & ~32'hF);
    check(lastWbData === shadowLine(setAddr(3)), "R6", "writeback data", lastWbData,
          shadowLine(setAddr(3)));
    check(lastWbSeq < lastRdSeq, "R6", "writeback precedes refill", lastWbSeq, lastRdSeq);
    // Survivors hit, evicted lines miss
    readCheck(setAddr(1), "R7", lat);
    check(lat == 1, "R7", "T1 still resident", lat, 1);
    readCheck(setAddr(4), "R7", lat);
    check(lat == 1, "R7", "T4 still resident", lat, 1);
    r0 = memReads;
    readCheck(setAddr(2), "R7", lat);
    check(memReads == r0 + 1, "R7", "T2 was evicted", memReads, r0 + 1);
    readCheck(setAddr(3), "R6", lat);
    // Other sets untouched
    readCheck(32'h0000_0234, "R9", lat);
    check(lat == 1, "R9", "other set still hits", lat, 1);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) begin
      for (int j = 0; j < 4; j++) begin
        shadow[k][j] = 32'hA500_0000 ^ (32'(k) << 8) ^ 32'(j * 17);
        backing[k][j*32 +: 32] = shadow[k][j];
      end
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    reqStrb = '0; memReady = 1'b0; memRespValid = 1'b0; memRdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadMissHit();
    testWriteHit();
    testWriteMiss();
    testLruOrder();
    check(readyViol == 0, "R8", "reqReady low while busy", readyViol, 0);
    check(holdViol == 0, "R10", "memory request held while stalled", holdViol, 0);
    check(stallSeen > 0, "R10", "stalled handshakes exercised", stallSeen, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule